// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block produces the 12-bit address of the next microinstruction in a microcoded controller. On each cycle it reads a 4-bit sequencing operation, a condition code with a force-pass control, and a 12-bit direct address. From these it picks the output address from one of four sources: the direct input, an internal register/counter, the microprogram counter, or the top of a return stack. A zero address is used for the reset-style jump.

On every rising edge it updates its state. The microprogram counter takes the chosen address plus a carry-in bit. The register/counter can load, count down or hold. A nine-entry return stack can push, pop, clear or hold. Three active-low, one-hot select lines tell the surrounding logic which external source should drive the direct input: the pipeline word, a mapping table, or a vector address. The address bus floats when output enable is high.

Top module: `useq_addr_seq`

## Requirements
- R1: The condition passes when `cc_n` is 0 or when `cc_en_n` is 1. With `cc_en_n` at 1 the value of `cc_n` has no effect.
- R2: The output address depends on `instr`. Here D is `din`, R is the register/counter, P is the microprogram counter, T is the stack top and "pass" is the R1 condition.
  - 0: address 0.
  - 1 and 3: D on pass, else P.
  - 2: D.
  - 4: P.
  - 5: D on pass, else R.
  - 6: D on pass, else P.
  - 7: D on pass, else R.
  - 8: T if R is nonzero, else P.
  - 9: D if R is nonzero, else P.
  - 10: T on pass, else P.
  - 11: D on pass, else P.
  - 12: P.
  - 13: P on pass, else T.
  - 14: P.
  - 15: P on pass; on fail, T if R is nonzero, else D.
- R3: Exactly one select line is low at any time. `sel_map_n` is low for code 2 and `sel_vec_n` is low for code 6. `sel_pipe_n` is low for every other code.
- R4: On each rising edge the microprogram counter loads the output address plus `carry_in`. With `carry_in` at 0 it repeats the current address.
- R5: While `reg_load_n` is 0, the register/counter loads `din` on the edge, whatever the code or condition. Otherwise it loads `din` for code 12, and for code 4 when the condition passes.
- R6: For codes 8, 9 and 15, the register/counter decrements by one when it is nonzero. For codes 8 and 9 it holds at zero. For code 15 it holds whenever it is zero.
- R7: Every push stores the current microprogram counter.
  - Codes 4 and 5 always push.
  - Code 1 pushes on pass.
  - `full_n` is low exactly while nine entries are held.
  - A push while full overwrites the top entry, and the count stays at nine.
- R8: Pops happen in these cases:
  - Codes 10 and 11 pop on pass.
  - Code 13 pops on pass.
  - Code 8 pops when R is zero.
  - Code 15 pops on pass, or on fail when R is zero.

  A pop from an empty stack leaves it empty. Code 0 empties the stack.
- R9: While `out_en_n` is 1, `addr_out` is high impedance.
- R10: A low `rst_n` at once clears the microprogram counter, the register/counter and the stack count. Release takes effect two rising edges after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 4 | Sequencing operation code |
| cc_n | input | 1 | Condition code, low means pass |
| cc_en_n | input | 1 | High forces the condition to pass |
| reg_load_n | input | 1 | Low loads the register/counter from `din` |
| out_en_n | input | 1 | High floats `addr_out` |
| carry_in | input | 1 | Incrementer carry into the microprogram counter |
| din | input | 12 | Direct address input |
| addr_out | output | 12 | Next microinstruction address |
| full_n | output | 1 | Low when the stack holds nine entries |
| sel_pipe_n | output | 1 | Selects the pipeline word as direct source |
| sel_map_n | output | 1 | Selects the mapping table as direct source |
| sel_vec_n | output | 1 | Selects the vector address as direct source |

## Verification
The microprogram counter shows up on `addr_out` in the very next cycle of any continue operation, so a wrong counter value is visible after one edge. A wrong stack pointer or wrong stack contents stay hidden until a return, a loop test or the full flag exposes them. The bench therefore fills the stack past nine entries, pops it past empty, and then pushes and returns again to show where the pointer stands. A wrong register/counter value appears only through the R-sourced jumps or through the point where a counted loop exits. For that reason loops are run to completion and the register is read back through code 7 with the condition failing.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [3:0] {
    OP_JZ   = 4'd0,
    OP_CJS  = 4'd1,
    OP_JMAP = 4'd2,
    OP_CJP  = 4'd3,
    OP_PUSH = 4'd4,
    OP_JSRP = 4'd5,
    OP_CJV  = 4'd6,
    OP_JRP  = 4'd7,
    OP_RFCT = 4'd8,
    OP_RPCT = 4'd9,
    OP_CRTN = 4'd10,
    OP_CJPP = 4'd11,
    OP_LDCT = 4'd12,
    OP_LOOP = 4'd13,
    OP_CONT = 4'd14,
    OP_TWB  = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    SRC_DIN = 2'd0,
    SRC_RC  = 2'd1,
    SRC_UPC = 2'd2,
    SRC_TOP = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_CLR  = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    RC_HOLD = 2'd0,
    RC_LOAD = 2'd1,
    RC_DEC  = 2'd2
  } rc_op_e;

  // one-hot select, active high internally: bit0 pipe, bit1 map, bit2 vector
  localparam int unsigned NSEL = 3;

endpackage

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  logic [3:0]      instr,
  input  logic            pass,
  input  logic            rc_zero,
  output src_e            src,
  output logic            force_zero,
  output stk_op_e         stk_op,
  output rc_op_e          rc_op,
  output logic [NSEL-1:0] ext_sel
);

  op_e op;
  assign op = op_e'(instr);

  always_comb begin
    src        = SRC_UPC;
    force_zero = 1'b0;
    stk_op     = STK_HOLD;
    rc_op      = RC_HOLD;
    ext_sel    = 3'b001;
    case (op)
      OP_JZ: begin
        force_zero = 1'b1;
        stk_op     = STK_CLR;
      end
      OP_CJS: begin
        if (pass) begin
          src    = SRC_DIN;
          stk_op = STK_PUSH;
        end
      end
      OP_JMAP: begin
        src     = SRC_DIN;
        ext_sel = 3'b010;
      end
      OP_CJP: begin
        if (pass) src = SRC_DIN;
      end
      OP_PUSH: begin
        stk_op = STK_PUSH;
        if (pass) rc_op = RC_LOAD;
      end
      OP_JSRP: begin
        stk_op = STK_PUSH;
        src    = pass ? SRC_DIN : SRC_RC;
      end
      OP_CJV: begin
        ext_sel = 3'b100;
        if (pass) src = SRC_DIN;
      end
      OP_JRP: begin
        src = pass ? SRC_DIN : SRC_RC;
      end
      OP_RFCT: begin
        if (!rc_zero) begin
          src   = SRC_TOP;
          rc_op = RC_DEC;
        end else begin
          stk_op = STK_POP;
        end
      end
      OP_RPCT: begin
        if (!rc_zero) begin
          src   = SRC_DIN;
          rc_op = RC_DEC;
        end
      end
      OP_CRTN: begin
        if (pass) begin
          src    = SRC_TOP;
          stk_op = STK_POP;
        end
      end
      OP_CJPP: begin
        if (pass) begin
          src    = SRC_DIN;
          stk_op = STK_POP;
        end
      end
      OP_LDCT: begin
        rc_op = RC_LOAD;
      end
      OP_LOOP: begin
        if (pass) stk_op = STK_POP;
        else      src    = SRC_TOP;
      end
      OP_CONT: begin
        src = SRC_UPC;
      end
      OP_TWB: begin
        if (!rc_zero) rc_op = RC_DEC;
        if (pass) begin
          stk_op = STK_POP;
        end else if (!rc_zero) begin
          src = SRC_TOP;
        end else begin
          src    = SRC_DIN;
          stk_op = STK_POP;
        end
      end
      default: begin
        src = SRC_UPC;
      end
    endcase
  end

endmodule

// File: rtl/useq_regcnt.sv
module useq_regcnt
  import useq_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  rc_op_e       op,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         is_zero
);

  logic [W-1:0] q_nx;
  logic         q_en;

  always_comb begin
    q_en = 1'b1;
    q_nx = q;
    if (!load_n) begin
      q_nx = din;
    end else begin
      case (op)
        RC_LOAD: q_nx = din;
        RC_DEC:  q_nx = q - {{(W-1){1'b0}}, 1'b1};
        default: q_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nx;
  end

  assign is_zero = (q == '0);

endmodule

// File: rtl/useq_stack.sv
module useq_stack
  import useq_pkg::*;
#(
  parameter int W     = 12,
  parameter int DEPTH = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  stk_op_e      op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top,
  output logic         full
);

  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] SP_MAX = PW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] sp_q, sp_nx;
  logic [PW-1:0] widx, ridx;
  logic          we;

  assign full = (sp_q == SP_MAX);
  assign we   = (op == STK_PUSH);
  assign widx = full ? (SP_MAX - 1'b1) : sp_q;
  assign ridx = (sp_q == '0) ? '0 : (sp_q - 1'b1);
  assign top  = mem[ridx];

  always_comb begin
    sp_nx = sp_q;
    case (op)
      STK_PUSH: if (!full)       sp_nx = sp_q + 1'b1;
      STK_POP:  if (sp_q != '0)  sp_nx = sp_q - 1'b1;
      STK_CLR:                   sp_nx = '0;
      default:                   sp_nx = sp_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_nx;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (we && (widx == PW'(i))) mem[i] <= wdata;
    end
  end

endmodule

// File: rtl/useq_addr_seq.sv
module useq_addr_seq
  import useq_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DEPTH = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    instr,
  input  logic          cc_n,
  input  logic          cc_en_n,
  input  logic          reg_load_n,
  input  logic          out_en_n,
  input  logic          carry_in,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] addr_out,
  output logic          full_n,
  output logic          sel_pipe_n,
  output logic          sel_map_n,
  output logic          sel_vec_n
);

  // reset: asserted at once, released after two edges
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  logic            pass;
  logic            rc_zero;
  src_e            src;
  logic            force_zero;
  stk_op_e         stk_op;
  rc_op_e          rc_op;
  logic [NSEL-1:0] ext_sel;
  logic [AW-1:0]   rc_q, upc, upc_nx, stk_top, y;
  logic            stk_full;

  assign pass = cc_en_n | ~cc_n;

  useq_decode u_dec (
    .instr      (instr),
    .pass       (pass),
    .rc_zero    (rc_zero),
    .src        (src),
    .force_zero (force_zero),
    .stk_op     (stk_op),
    .rc_op      (rc_op),
    .ext_sel    (ext_sel)
  );

  useq_regcnt #(.W(AW)) u_rc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_n  (reg_load_n),
    .op      (rc_op),
    .din     (din),
    .q       (rc_q),
    .is_zero (rc_zero)
  );

  useq_stack #(.W(AW), .DEPTH(DEPTH)) u_stk (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .op    (stk_op),
    .wdata (upc),
    .top   (stk_top),
    .full  (stk_full)
  );

  always_comb begin
    if (force_zero) begin
      y = '0;
    end else begin
      case (src)
        SRC_DIN: y = din;
        SRC_RC:  y = rc_q;
        SRC_TOP: y = stk_top;
        default: y = upc;
      endcase
    end
  end

  assign upc_nx = y + AW'(carry_in);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) upc <= '0;
    else             upc <= upc_nx;
  end

  assign addr_out   = out_en_n ? {AW{1'bz}} : y;
  assign full_n     = ~stk_full;
  assign sel_pipe_n = ~ext_sel[0];
  assign sel_map_n  = ~ext_sel[1];
  assign sel_vec_n  = ~ext_sel[2];

endmodule

// File: rtl/useq_addr_seq_chk.sv
module useq_addr_seq_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic [3:0]    instr,
  input logic          cc_n,
  input logic          cc_en_n,
  input logic          reg_load_n,
  input logic          carry_in,
  input logic [AW-1:0] din,
  input logic [AW-1:0] y,
  input logic [AW-1:0] upc,
  input logic [AW-1:0] rc_q,
  input logic          full_n,
  input logic          sel_pipe_n,
  input logic          sel_map_n,
  input logic          sel_vec_n
);

  p_forced_pass_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr == 4'd3 && cc_en_n) |-> (y == din));

  p_fail_cjp_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr == 4'd3 && !cc_en_n && cc_n) |-> (y == upc));

  p_map_sel_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr == 4'd2) |-> (!sel_map_n && sel_pipe_n && sel_vec_n));

  p_onehot_sel_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_sync_n |-> ($countones({sel_pipe_n, sel_map_n, sel_vec_n}) == 2));

  p_upc_next_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_sync_n |=> (upc == $past(y) + AW'($past(carry_in))));

  p_rc_load_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !reg_load_n |=> (rc_q == $past(din)));

  p_full_stays_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!full_n && instr == 4'd4) |=> !full_n);

  p_jz_zero_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr == 4'd0) |-> (y == '0));

  p_jz_clear_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr == 4'd0) |=> full_n);

endmodule

bind useq_addr_seq useq_addr_seq_chk #(.AW(AW)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .instr      (instr),
  .cc_n       (cc_n),
  .cc_en_n    (cc_en_n),
  .reg_load_n (reg_load_n),
  .carry_in   (carry_in),
  .din        (din),
  .y          (y),
  .upc        (upc),
  .rc_q       (rc_q),
  .full_n     (full_n),
  .sel_pipe_n (sel_pipe_n),
  .sel_map_n  (sel_map_n),
  .sel_vec_n  (sel_vec_n)
);

// File: tb/useq_addr_seq_tb_top.sv
`timescale 1ns/1ps
module useq_addr_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  instr;
  logic        cc_n, cc_en_n, reg_load_n, out_en_n, carry_in;
  logic [11:0] din;
  wire  [11:0] addr_out;
  wire         full_n, sel_pipe_n, sel_map_n, sel_vec_n;

  always #10 clk = ~clk;

  useq_addr_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr      (instr),
    .cc_n       (cc_n),
    .cc_en_n    (cc_en_n),
    .reg_load_n (reg_load_n),
    .out_en_n   (out_en_n),
    .carry_in   (carry_in),
    .din        (din),
    .addr_out   (addr_out),
    .full_n     (full_n),
    .sel_pipe_n (sel_pipe_n),
    .sel_map_n  (sel_map_n),
    .sel_vec_n  (sel_vec_n)
  );

  typedef struct {
    logic [11:0] y;
    logic [2:0]  sel;   // {vec_n, map_n, pipe_n}
    logic        full;  // expected full_n
    logic        z;     // output floated
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // reference state
  logic [11:0] m_upc, m_rc;
  int          m_sp;
  logic [11:0] m_stk [9];

  task automatic check(input logic ok, input string tag, input logic [11:0] act,
                       input logic [11:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_upc = '0;
    m_rc  = '0;
    m_sp  = 0;
    for (int i = 0; i < 9; i++) m_stk[i] = '0;
  endtask

  task automatic drive(input logic [3:0] op, input logic ccn, input logic cen,
                       input logic ldn, input logic ci, input logic [11:0] d,
                       input logic oen, input string tag);
    logic        ok_pass, nz, push, pop, clr, ld, dec;
    logic [11:0] top, ey;
    logic [2:0]  es;
    exp_t        e;
    @(negedge clk);
    instr = op; cc_n = ccn; cc_en_n = cen; reg_load_n = ldn;
    carry_in = ci; din = d; out_en_n = oen;
    ok_pass = cen || !ccn;
    nz   = (m_rc != 0);
    top  = (m_sp > 0) ? m_stk[m_sp-1] : m_stk[0];
    push = 0; pop = 0; clr = 0; ld = 0; dec = 0;
    ey   = m_upc;
    es   = 3'b110;
    if (op == 0) begin ey = 0; clr = 1; end
    else if (op == 1) begin if (ok_pass) begin ey = d; push = 1; end end
    else if (op == 2) begin ey = d; es = 3'b101; end
    else if (op == 3) begin if (ok_pass) ey = d; end
    else if (op == 4) begin push = 1; ld = ok_pass; end
    else if (op == 5) begin push = 1; ey = ok_pass ? d : m_rc; end
    else if (op == 6) begin es = 3'b011; if (ok_pass) ey = d; end
    else if (op == 7) begin ey = ok_pass ? d : m_rc; end
    else if (op == 8) begin if (nz) begin ey = top; dec = 1; end else pop = 1; end
    else if (op == 9) begin if (nz) begin ey = d; dec = 1; end end
    else if (op == 10) begin if (ok_pass) begin ey = top; pop = 1; end end
    else if (op == 11) begin if (ok_pass) begin ey = d; pop = 1; end end
    else if (op == 12) begin ld = 1; end
    else if (op == 13) begin if (ok_pass) pop = 1; else ey = top; end
    else if (op == 15) begin
      dec = nz;
      if (ok_pass) pop = 1;
      else if (nz) ey = top;
      else begin ey = d; pop = 1; end
    end
    e.y = ey; e.sel = es; e.full = (m_sp == 9) ? 1'b0 : 1'b1; e.z = oen; e.tag = tag;
    q.push_back(e);
    // state after the edge
    if (!ldn || ld) m_rc = d;
    else if (dec)   m_rc = m_rc - 1;
    if (clr) m_sp = 0;
    else if (push) begin
      if (m_sp == 9) m_stk[8] = m_upc;
      else begin m_stk[m_sp] = m_upc; m_sp++; end
    end else if (pop && m_sp > 0) m_sp--;
    m_upc = ey + {11'd0, ci};
  endtask

  // monitor: compares each cycle's outputs with the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.z) begin
          check(addr_out !== e.y, "R9", addr_out, e.y, "floating bus");
        end else begin
          check(addr_out === e.y, e.tag, addr_out, e.y, "address");
        end
        check({sel_vec_n, sel_map_n, sel_pipe_n} === e.sel, "R3",
              {9'd0, sel_vec_n, sel_map_n, sel_pipe_n}, {9'd0, e.sel}, "selects");
        check(full_n === e.full, "R7", {11'd0, full_n}, {11'd0, e.full}, "full flag");
      end
    end
  end

  // watchdog
  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; instr = 4'd14; cc_n = 1; cc_en_n = 0; reg_load_n = 1;
    out_en_n = 0; carry_in = 0; din = '0;
    model_reset();
    repeat (3) @(negedge clk);
    #5;
    check(full_n === 1'b1, "R10", {11'd0, full_n}, 12'd1, "full in reset");
    check(addr_out === 12'd0, "R10", addr_out, 12'd0, "address in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: counter starts from zero
    drive(14, 1, 0, 1, 1, 12'h000, 0, "R10");
    // R4: carry in advances or holds
    drive(14, 1, 0, 1, 1, 12'h000, 0, "R4");
    drive(14, 1, 0, 1, 0, 12'h000, 0, "R4");
    drive(14, 1, 0, 1, 1, 12'h000, 0, "R4");
    // R1: pass, fail, forced pass
    drive(3, 0, 0, 1, 1, 12'h100, 0, "R1");
    drive(3, 1, 0, 1, 1, 12'h1ff, 0, "R1");
    drive(3, 1, 1, 1, 1, 12'h150, 0, "R1");
    // R3: map and vector selects
    drive(2, 1, 0, 1, 1, 12'h3a0, 0, "R3");
    drive(6, 1, 0, 1, 1, 12'h7c0, 0, "R3");
    drive(6, 0, 0, 1, 1, 12'h7c0, 0, "R3");
    // R7 subroutine call and return
    drive(1, 0, 0, 1, 1, 12'h200, 0, "R7");
    drive(14, 1, 0, 1, 1, 12'h000, 0, "R2");
    drive(10, 0, 0, 1, 1, 12'h000, 0, "R2");
    // R5: load counter, then count loop R6
    drive(12, 1, 0, 1, 1, 12'h003, 0, "R5");
    for (int i = 0; i < 5; i++) drive(9, 1, 0, 1, 1, 12'h040, 0, "R6");
    // R6: register loop to stack top
    drive(4, 0, 0, 1, 1, 12'h002, 0, "R6");
    for (int i = 0; i < 4; i++) drive(8, 1, 0, 1, 1, 12'h000, 0, "R6");
    // R5: strobe load overrides the operation
    drive(14, 1, 0, 0, 1, 12'h055, 0, "R5");
    drive(7, 1, 0, 1, 1, 12'h999, 0, "R5");
    drive(4, 1, 0, 0, 1, 12'h0a5, 0, "R5");
    drive(7, 1, 0, 1, 1, 12'h999, 0, "R5");
    drive(10, 0, 0, 1, 1, 12'h000, 0, "R8");
    // R7: fill past nine entries
    for (int i = 0; i < 11; i++) drive(4, 1, 0, 1, 1, 12'h000, 0, "R7");
    // R8: pop past empty, then push and return
    for (int i = 0; i < 11; i++) drive(10, 0, 0, 1, 1, 12'h000, 0, "R8");
    drive(1, 0, 0, 1, 1, 12'h321, 0, "R8");
    drive(10, 0, 0, 1, 1, 12'h000, 0, "R8");
    drive(10, 1, 0, 1, 1, 12'h000, 0, "R8");
    // R6 / R2: three-way branch, all outcomes
    drive(4, 0, 0, 1, 1, 12'h002, 0, "R6");
    drive(4, 1, 0, 1, 1, 12'h000, 0, "R6");
    drive(15, 1, 0, 1, 1, 12'h444, 0, "R6");
    drive(15, 0, 0, 1, 1, 12'h444, 0, "R6");
    drive(15, 1, 0, 1, 1, 12'h444, 0, "R6");
    drive(15, 1, 0, 1, 1, 12'h444, 0, "R6");
    // R2: other codes
    drive(5, 1, 0, 1, 1, 12'h600, 0, "R2");
    drive(5, 0, 0, 1, 1, 12'h610, 0, "R2");
    drive(13, 1, 0, 1, 1, 12'h000, 0, "R2");
    drive(13, 0, 0, 1, 1, 12'h000, 0, "R2");
    drive(11, 0, 0, 1, 1, 12'h720, 0, "R2");
    drive(11, 1, 0, 1, 1, 12'h720, 0, "R2");
    // R9: floated bus (expected address nonzero)
    drive(3, 0, 0, 1, 1, 12'h5a5, 1, "R9");
    // R8: zero jump empties the stack
    drive(4, 1, 0, 1, 1, 12'h000, 0, "R8");
    drive(0, 1, 0, 1, 1, 12'h000, 0, "R8");
    drive(14, 1, 0, 1, 1, 12'h000, 0, "R8");

    // R2: random sequence
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      if (m_sp == 0 && (op == 8 || op == 10 || op == 13 || op == 15)) op = 4'd14;
      drive(op, 1'($urandom), 1'($urandom_range(0, 3) == 0),
            1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 5) != 0),
            12'($urandom), 0, "R2");
    end

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    // R10: asynchronous assertion mid-cycle
    instr = 4'd14; out_en_n = 0;
    #2 rst_n = 1'b0;
    #3;
    check(addr_out === 12'd0, "R10", addr_out, 12'd0, "async reset address");
    check(full_n === 1'b1, "R10", {11'd0, full_n}, 12'd1, "async reset full");

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule